// File: doc/BRIEF.md
# Serial Text Buffer Command Writer

This block keeps a short text message, sixteen characters by default, in a bank of registers and rewrites it from a stream of received bytes. Each input byte arrives with a one-cycle valid strobe, as a serial receiver would deliver it. Two byte values are treated as commands rather than text. Carriage return (0x0D) moves the write position back to the start. Escape (0x1B) blanks the whole message and also moves the write position back to the start. Every other byte is written at the current write position, and the position then advances. After the last entry it wraps to the first.

A display driver reads the message through a combinational port indexed by character position. It watches a one-cycle update pulse so that it can restart its scan whenever the stored text changes. Each valid byte is decoded into one of four commands: hold (no valid byte), store, rewind and blank. A single `unique case` over that command drives the pointer and the update pulse.

A synchronous reset reloads the preset message and clears the pointer. The registers are given the same preset at power-up, so the contents after power-up and after reset are identical.

Top module: `msgbuf_writer`

## Requirements
- R1: While reset is high at a clock edge, the write pointer returns to 0 and all sixteen entries reload the preset text "MSG BUFFER READY" (entry 0 = 'M', entry 15 = 'Y'). Reset takes priority over a valid byte presented in the same cycle, and the update pulse is low after reset.
- R2: A valid byte other than 0x0D and 0x1B is written to the entry at the write pointer, and the pointer advances by one. No other entry changes.
- R3: A store at entry 15 wraps the pointer to 0, so the seventeenth character after a rewind overwrites entry 0.
- R4: A valid 0x0D sets the write pointer to 0 and leaves all sixteen entries unchanged.
- R5: A valid 0x1B writes 0x20 (space) into all sixteen entries at one clock edge and sets the write pointer to 0.
- R6: When the valid strobe is low, the byte input is ignored: storage, pointer and update pulse do not change.
- R7: The read port returns the entry selected by the read index combinationally. During a cycle in which the same entry is being written, the port still shows the old value until the clock edge.
- R8: The update pulse is high for exactly the one cycle after each edge that stores a byte or blanks the message, and low otherwise. Back-to-back stores give a pulse in each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| rx_valid_i | input | 1 | One-cycle strobe marking a received byte |
| rx_byte_i | input | 8 | Received byte |
| rd_idx_i | input | 4 | Character position to read |
| rd_char_o | output | 8 | Stored character at rd_idx_i (combinational) |
| upd_o | output | 1 | Pulse in the cycle after storage changed |

## Verification
Two functions can land in one cycle: a write into an entry, and the display reading that same entry. The bench provokes this by presenting a valid byte while the read index equals the write position. It samples the read port before the clock edge, where the old character is expected, and again after the edge, where the new one is expected. Reset arriving together with a valid byte is the second collision. It is judged by the preset text being intact and the next character landing at entry 0.

// File: rtl/msgbuf_pkg.sv
package msgbuf_pkg;

    localparam int unsigned CHAR_W     = 8;
    localparam logic [7:0]  CH_REWIND  = 8'h0D;
    localparam logic [7:0]  CH_BLANK   = 8'h1B;
    localparam logic [7:0]  CH_SPACE   = 8'h20;

    typedef enum logic [1:0] {
        CMD_HOLD,
        CMD_STORE,
        CMD_REWIND,
        CMD_BLANK
    } cmd_e;

    localparam int unsigned          PRESET_LEN  = 16;
    localparam logic [8*PRESET_LEN-1:0] PRESET_TEXT = "MSG BUFFER READY";

    // Character of the power-up/reset message at a position; blank past its end.
    function automatic logic [7:0] preset_char(input int unsigned idx);
        if (idx < PRESET_LEN)
            return PRESET_TEXT[8*(PRESET_LEN-1-idx) +: 8];
        else
            return CH_SPACE;
    endfunction

endpackage

// File: rtl/msgbuf_decode.sv
module msgbuf_decode
    import msgbuf_pkg::*;
(
    input  logic        valid_i,
    input  logic [7:0]  byte_i,
    output cmd_e        cmd_o
);

    always_comb begin
        if (!valid_i) begin
            cmd_o = CMD_HOLD;
        end else begin
            unique case (byte_i)
                CH_REWIND: cmd_o = CMD_REWIND;
                CH_BLANK:  cmd_o = CMD_BLANK;
                default:   cmd_o = CMD_STORE;
            endcase
        end
    end

endmodule

// File: rtl/msgbuf_ctrl.sv
module msgbuf_ctrl
    import msgbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  cmd_e             cmd_i,
    output logic [PTR_W-1:0] wr_ptr_o,
    output logic             wr_en_o,
    output logic             clr_en_o,
    output logic             upd_o
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_d;
    logic             upd_d;

    always_comb begin
        ptr_d = ptr_q;
        upd_d = 1'b0;
        unique case (cmd_i)
            CMD_HOLD:   ptr_d = ptr_q;
            CMD_STORE: begin
                ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
                upd_d = 1'b1;
            end
            CMD_REWIND: ptr_d = '0;
            CMD_BLANK: begin
                ptr_d = '0;
                upd_d = 1'b1;
            end
            default:    ptr_d = ptr_q;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ptr_q <= '0;
            upd_o <= 1'b0;
        end else begin
            ptr_q <= ptr_d;
            upd_o <= upd_d;
        end
    end

    assign wr_ptr_o = ptr_q;
    assign wr_en_o  = (cmd_i == CMD_STORE);
    assign clr_en_o = (cmd_i == CMD_BLANK);

endmodule

// File: rtl/msgbuf_store.sv
module msgbuf_store
    import msgbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_en_i,
    input  logic             clr_en_i,
    input  logic [PTR_W-1:0] wr_ptr_i,
    input  logic [7:0]       wr_data_i,
    input  logic [PTR_W-1:0] rd_idx_i,
    output logic [7:0]       rd_data_o
);

    logic [7:0]       cells [DEPTH];
    logic [DEPTH-1:0] hit;

    for (genvar g = 0; g < DEPTH; g++) begin : g_sel
        assign hit[g] = wr_en_i && (wr_ptr_i == PTR_W'(g));
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) cells[i] = preset_char(i);
    end

    always_ff @(posedge clk_i) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst_i)
                cells[i] <= preset_char(i);
            else if (clr_en_i)
                cells[i] <= CH_SPACE;
            else if (hit[i])
                cells[i] <= wr_data_i;
        end
    end

    assign rd_data_o = cells[rd_idx_i];

endmodule

// File: rtl/msgbuf_writer.sv
module msgbuf_writer
    import msgbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             rx_valid_i,
    input  logic [7:0]       rx_byte_i,
    input  logic [PTR_W-1:0] rd_idx_i,
    output logic [7:0]       rd_char_o,
    output logic             upd_o
);

    cmd_e             cmd;
    logic [PTR_W-1:0] wr_ptr;
    logic             wr_en;
    logic             clr_en;

    msgbuf_decode u_decode (
        .valid_i (rx_valid_i),
        .byte_i  (rx_byte_i),
        .cmd_o   (cmd)
    );

    msgbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .cmd_i    (cmd),
        .wr_ptr_o (wr_ptr),
        .wr_en_o  (wr_en),
        .clr_en_o (clr_en),
        .upd_o    (upd_o)
    );

    msgbuf_store #(.DEPTH(DEPTH)) u_store (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en),
        .clr_en_i  (clr_en),
        .wr_ptr_i  (wr_ptr),
        .wr_data_i (rx_byte_i),
        .rd_idx_i  (rd_idx_i),
        .rd_data_o (rd_char_o)
    );

endmodule

// File: rtl/msgbuf_writer_chk.sv
module msgbuf_writer_chk #(
    parameter int unsigned PTR_W = 4
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             rx_valid_i,
    input logic [7:0]       rx_byte_i,
    input logic [PTR_W-1:0] rd_idx_i,
    input logic [7:0]       rd_char_o,
    input logic             upd_o
);

    // R2: a text byte always produces the update pulse
    a_r2_store_pulses: assert property (@(posedge clk_i) disable iff (rst_i)
        (rx_valid_i && rx_byte_i != 8'h0D && rx_byte_i != 8'h1B) |=> upd_o);

    // R4: a rewind never signals a change
    a_r4_rewind_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        (rx_valid_i && rx_byte_i == 8'h0D) |=> !upd_o);

    // R5: after a blank, whatever entry is read shows a space
    a_r5_blank_all: assert property (@(posedge clk_i) disable iff (rst_i)
        (rx_valid_i && rx_byte_i == 8'h1B) |=> (rd_char_o == 8'h20));

    // R6: no strobe, no pulse
    a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        !rx_valid_i |=> !upd_o);

    // R7/R4: with storage untouched, a held index reads a held value
    a_r7_stable_read: assert property (@(posedge clk_i) disable iff (rst_i)
        (!rx_valid_i || rx_byte_i == 8'h0D) |=> ($stable(rd_idx_i) -> $stable(rd_char_o)));

    // R8: a pulse always follows a strobed byte
    a_r8_pulse_cause: assert property (@(posedge clk_i) disable iff (rst_i)
        upd_o |-> $past(rx_valid_i));

endmodule

bind msgbuf_writer msgbuf_writer_chk #(.PTR_W(PTR_W)) chk_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .rx_valid_i (rx_valid_i),
    .rx_byte_i  (rx_byte_i),
    .rd_idx_i   (rd_idx_i),
    .rd_char_o  (rd_char_o),
    .upd_o      (upd_o)
);

// File: tb/msgbuf_writer_tb_top.sv
module msgbuf_writer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic [3:0] rd_idx = 4'd0;
    logic [7:0] rd_char;
    logic       upd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_mem [N];
    int         exp_ptr;
    localparam logic [8*N-1:0] PRESET = "MSG BUFFER READY";

    always #(CLK_PERIOD/2) clk = ~clk;

    msgbuf_writer dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .rx_valid_i (rx_valid),
        .rx_byte_i  (rx_byte),
        .rd_idx_i   (rd_idx),
        .rd_char_o  (rd_char),
        .upd_o      (upd)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_preset();
        for (int i = 0; i < N; i++) exp_mem[i] = PRESET[8*(N-1-i) +: 8];
        exp_ptr = 0;
    endtask

    // Compare every entry through the read port (valid is low here).
    task automatic check_all(input string req);
        for (int i = 0; i < N; i++) begin
            rd_idx = 4'(i);
            #1;
            check(req, rd_char, exp_mem[i]);
        end
    endtask

    // Present one byte for one cycle, update the model, check the pulse.
    task automatic push(input logic [7:0] b, input string req);
        logic exp_upd;
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        if (b == 8'h0D) begin
            exp_ptr = 0; exp_upd = 1'b0;
        end else if (b == 8'h1B) begin
            for (int i = 0; i < N; i++) exp_mem[i] = 8'h20;
            exp_ptr = 0; exp_upd = 1'b1;
        end else begin
            exp_mem[exp_ptr] = b;
            exp_ptr = (exp_ptr + 1) % N;
            exp_upd = 1'b1;
        end
        @(negedge clk);
        rx_valid = 1'b0;
        check({req, " R8 pulse"}, {7'd0, upd}, {7'd0, exp_upd});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_preset();
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 pulse low", {7'd0, upd}, 8'd0);
        check_all("R1 preset");
    endtask

    task automatic t_store();
        push("A", "R2");
        push("b", "R2");
        check_all("R2 contents");
    endtask

    task automatic t_idle();
        @(negedge clk);
        rx_byte = "Z";
        rx_valid = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check("R6 no pulse", {7'd0, upd}, 8'd0);
        end
        check_all("R6 contents");
        push("c", "R6 position kept");
        check_all("R6 next store");
    endtask

    task automatic t_rewind();
        push(8'h0D, "R4");
        check_all("R4 unchanged");
        push("Q", "R4");
        rd_idx = 4'd0; #1;
        check("R4 lands at 0", rd_char, "Q");
        check_all("R4 contents");
    endtask

    task automatic t_wrap();
        push(8'h0D, "R3");
        for (int i = 0; i < 17; i++) push(8'h61 + 8'(i), "R3");
        rd_idx = 4'd0; #1;
        check("R3 wrap overwrites 0", rd_char, 8'h71);
        rd_idx = 4'd1; #1;
        check("R3 entry 1 kept", rd_char, 8'h62);
        check_all("R3 contents");
    endtask

    task automatic t_blank();
        push("x", "R5");
        push(8'h1B, "R5");
        check_all("R5 all spaces");
        push("K", "R5");
        rd_idx = 4'd0; #1;
        check("R5 pointer at 0", rd_char, "K");
    endtask

    task automatic t_same_cycle();
        push(8'h0D, "R7");
        @(negedge clk);
        rd_idx   = 4'd0;
        rx_valid = 1'b1;
        rx_byte  = "W";
        #1;
        check("R7 old value before edge", rd_char, exp_mem[0]);
        exp_mem[0] = "W";
        exp_ptr = 1;
        @(negedge clk);
        rx_valid = 1'b0;
        #1;
        check("R7 new value after edge", rd_char, "W");
    endtask

    task automatic t_burst();
        push(8'h1B, "R8");
        @(negedge clk);
        rx_valid = 1'b1;
        for (int i = 0; i < 4; i++) begin
            rx_byte = 8'h30 + 8'(i);
            exp_mem[exp_ptr] = rx_byte;
            exp_ptr = (exp_ptr + 1) % N;
            @(negedge clk);
            check("R8 back-to-back pulse", {7'd0, upd}, 8'd1);
        end
        rx_valid = 1'b0;
        @(negedge clk);
        check("R8 pulse ends", {7'd0, upd}, 8'd0);
        check_all("R8 contents");
    endtask

    task automatic t_reset_priority();
        push("m", "R1");
        @(negedge clk);
        rst = 1'b1;
        rx_valid = 1'b1;
        rx_byte = "J";
        @(negedge clk);
        rst = 1'b0;
        rx_valid = 1'b0;
        model_preset();
        check("R1 pulse after reset", {7'd0, upd}, 8'd0);
        check_all("R1 reset beats valid");
        push("J", "R1");
        rd_idx = 4'd0; #1;
        check("R1 pointer at 0", rd_char, "J");
    endtask

    initial begin
        model_preset();
        repeat (2) @(negedge clk);
        t_reset();
        t_store();
        t_idle();
        t_rewind();
        t_wrap();
        t_blank();
        t_same_cycle();
        t_burst();
        t_reset_priority();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule